// File: doc/BRIEF.md
# Banked Interrupt Flag and Enable Controller

This block collects sixteen peripheral interrupt sources into four banks of four and presents one request line per bank to the processor. Bank 0 drives autovector priority level 3, bank 1 level 4, bank 2 level 5 and bank 3 level 6. Each bank keeps a pending-flag register and an enable register, both reached over a byte-wide register bus. A flag is latched on a rising edge of its source and stays set until software writes a one to it. The enable register is written with a set/clear convention: the top data bit picks whether the written ones set or clear enable bits.

A bank raises its level request while at least one source is both pending and enabled. Software that services a level reads the bank's flag register, whose top bit summarises whether the bank is requesting, and clears each flag it handles. Software numbers a source as eight times its level plus its bit index, so source i of bank b is interrupt (b+3)*8+i and appears on `src_i[4*b+i]`.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset every flag and enable bit is 0 and all four level requests are low; the flag register of each bank then reads 0x00 and its enable register reads 0x80.
- R2: Bank b (0 to 3) owns addresses 0x30 + 16*b to 0x3F + 16*b; its flag register is at offset 0 and its enable register at offset 4 within that range. Every other address reads 0x00 and a write to it changes nothing.
- R3: A write to an enable register with data bit 7 = 1 sets each enable bit whose data bit (3:0) is 1 and leaves the others unchanged.
- R4: A write to an enable register with data bit 7 = 0 clears each enable bit whose data bit (3:0) is 1 and leaves the others unchanged.
- R5: A flag bit becomes 1 in the clock cycle after its source input is first sampled high following a low sample; a source held high does not set the flag again once it has been cleared.
- R6: Writing 1 to flag-register bit i (i in 3:0) clears that flag; writing 0 leaves it unchanged.
- R7: When a source rising edge and a write-one-to-clear of the same flag happen in the same cycle, the flag ends up set.
- R8: Level request b (`lvl_req_o[b]`, priority level b+3) is high exactly while some bit of bank b is both flagged and enabled, and low otherwise.
- R9: The flag register reads bit 7 as the bank's request and bits 3:0 as its flags; the enable register reads bit 7 as 1 and bits 3:0 as its enables; bits 6:4 always read 0 and written values in bits 6:4 have no effect.
- R10: The four banks are independent: sources, flag writes and enable writes of one bank never change another bank's flags, enables or request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 16 | Interrupt sources, bit 4*b+i is source i of bank b |
| we_i | input | 1 | Register write strobe for the current address |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for `addr_i`, combinational |
| lvl_req_o | output | 4 | Level requests, bit b drives priority level b+3 |

## Verification
The hardest case to reach is a source edge landing in exactly the cycle that software clears the same flag, because the edge detector and the bus write must line up on one clock. The bench drives the source and the clearing write on the same falling edge so both are sampled together, and then also holds the source high through a later clear to show no second edge is seen. A long mixed phase drives random source patterns together with writes to all banks and to unmapped addresses, while a behavioural model checks every request line and the read data on every cycle.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  localparam int unsigned IRQB_BANKS    = 4;
  localparam int unsigned IRQB_SRCS     = 4;
  localparam int unsigned IRQB_AW       = 8;
  localparam int unsigned IRQB_DW       = 8;
  localparam int unsigned IRQB_BASE     = 'h30;
  localparam int unsigned IRQB_STRIDE   = 16;
  localparam int unsigned IRQB_FLAG_OFF = 0;
  localparam int unsigned IRQB_EN_OFF   = 4;
  localparam int unsigned IRQB_CTL_BIT  = 7;
  localparam int unsigned IRQB_SYNC     = 2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_FLAG = 2'd1,
    SEL_EN   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/irqb_rst_sync.sv
module irqb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/irqb_edge.sv
module irqb_edge #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb begin
    prev_d = src_i;
    rise_o = src_i & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/irqb_bank.sv
module irqb_bank #(
  parameter int unsigned SRCS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flag_wr_i,
  input  logic            en_wr_i,
  input  logic            set_i,
  input  logic [SRCS-1:0] bits_i,
  input  logic [SRCS-1:0] rise_i,
  output logic [SRCS-1:0] flag_o,
  output logic [SRCS-1:0] en_o,
  output logic            req_o
);
  logic [SRCS-1:0] flag_q, flag_d;
  logic [SRCS-1:0] en_q, en_d;
  logic            flag_ce, en_ce;
  logic [SRCS-1:0] clr_mask;

  always_comb begin
    clr_mask = flag_wr_i ? bits_i : '0;
    // a new edge wins over a clearing write in the same cycle
    flag_d   = (flag_q & ~clr_mask) | rise_i;
    flag_ce  = flag_wr_i | (|rise_i);
    en_d     = set_i ? (en_q | bits_i) : (en_q & ~bits_i);
    en_ce    = en_wr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= '0;
    else if (flag_ce) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign req_o  = |(flag_q & en_q);
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irqb_pkg::*;
#(
  parameter int unsigned BANKS    = IRQB_BANKS,
  parameter int unsigned SRCS     = IRQB_SRCS,
  parameter int unsigned AW       = IRQB_AW,
  parameter int unsigned DW       = IRQB_DW,
  parameter int unsigned BASE     = IRQB_BASE,
  parameter int unsigned STRIDE   = IRQB_STRIDE,
  parameter int unsigned FLAG_OFF = IRQB_FLAG_OFF,
  parameter int unsigned EN_OFF   = IRQB_EN_OFF,
  parameter int unsigned CTL_BIT  = IRQB_CTL_BIT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BANKS*SRCS-1:0] src_i,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  output logic [BANKS-1:0]      lvl_req_o
);
  localparam int unsigned NSRC  = BANKS * SRCS;
  localparam int unsigned OFF_W = $clog2(STRIDE);
  localparam int unsigned TAG_W = AW - OFF_W;

  logic                          rst_sn;
  logic [NSRC-1:0]               rise;
  logic [NSRC-1:0]               flag_all;
  logic [NSRC-1:0]               en_all;
  logic [BANKS-1:0][DW-1:0]      rd_bank;
  logic                          unused_wdata;

  assign unused_wdata = ^wdata_i;

  irqb_rst_sync #(.STAGES(IRQB_SYNC)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sn)
  );

  irqb_edge #(.W(NSRC)) u_edge (
    .clk    (clk),
    .rst_n  (rst_sn),
    .src_i  (src_i),
    .rise_o (rise)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam int unsigned   BBASE = BASE + b * STRIDE;
    localparam logic [TAG_W-1:0] BTAG = TAG_W'(BBASE >> OFF_W);

    reg_sel_e        sel;
    logic [SRCS-1:0] fq, eq;
    logic            req;
    logic [DW-1:0]   rd_v;

    always_comb begin
      sel = SEL_NONE;
      if (addr_i[AW-1:OFF_W] == BTAG) begin
        if (addr_i[OFF_W-1:0] == OFF_W'(FLAG_OFF))    sel = SEL_FLAG;
        else if (addr_i[OFF_W-1:0] == OFF_W'(EN_OFF)) sel = SEL_EN;
      end
    end

    irqb_bank #(.SRCS(SRCS)) u_bank (
      .clk       (clk),
      .rst_n     (rst_sn),
      .flag_wr_i (we_i && (sel == SEL_FLAG)),
      .en_wr_i   (we_i && (sel == SEL_EN)),
      .set_i     (wdata_i[CTL_BIT]),
      .bits_i    (wdata_i[SRCS-1:0]),
      .rise_i    (rise[b*SRCS +: SRCS]),
      .flag_o    (fq),
      .en_o      (eq),
      .req_o     (req)
    );

    always_comb begin
      rd_v = '0;
      case (sel)
        SEL_FLAG: begin
          rd_v[CTL_BIT]  = req;
          rd_v[SRCS-1:0] = fq;
        end
        SEL_EN: begin
          rd_v[CTL_BIT]  = 1'b1;
          rd_v[SRCS-1:0] = eq;
        end
        default: rd_v = '0;
      endcase
    end

    assign rd_bank[b]                = rd_v;
    assign flag_all[b*SRCS +: SRCS]  = fq;
    assign en_all[b*SRCS +: SRCS]    = eq;
    assign lvl_req_o[b]              = req;
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < BANKS; b++) rdata_o = rdata_o | rd_bank[b];
  end
endmodule

// File: rtl/irqb_checker.sv
module irqb_checker #(
  parameter int unsigned BANKS    = 4,
  parameter int unsigned SRCS     = 4,
  parameter int unsigned AW       = 8,
  parameter int unsigned DW       = 8,
  parameter int unsigned BASE     = 'h30,
  parameter int unsigned STRIDE   = 16,
  parameter int unsigned FLAG_OFF = 0,
  parameter int unsigned EN_OFF   = 4,
  parameter int unsigned CTL_BIT  = 7
) (
  input logic                  clk,
  input logic                  rst_sn,
  input logic [BANKS*SRCS-1:0] src_i,
  input logic                  we_i,
  input logic [AW-1:0]         addr_i,
  input logic [DW-1:0]         wdata_i,
  input logic [DW-1:0]         rdata_o,
  input logic [BANKS-1:0]      lvl_req_o,
  input logic [BANKS*SRCS-1:0] rise,
  input logic [BANKS*SRCS-1:0] flag_all,
  input logic [BANKS*SRCS-1:0] en_all
);
  logic unused_chk;
  logic mapped;

  assign unused_chk = ^wdata_i;

  always_comb begin
    mapped = 1'b0;
    for (int b = 0; b < BANKS; b++) begin
      if (addr_i == AW'(BASE + b*STRIDE + FLAG_OFF)) mapped = 1'b1;
      if (addr_i == AW'(BASE + b*STRIDE + EN_OFF))   mapped = 1'b1;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(rst_sn) |-> (lvl_req_o == '0));

  p_unmapped_read_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    !mapped |-> (rdata_o == '0));

  for (genvar b = 0; b < BANKS; b++) begin : g_b
    localparam logic [AW-1:0] FA = AW'(BASE + b*STRIDE + FLAG_OFF);
    localparam logic [AW-1:0] EA = AW'(BASE + b*STRIDE + EN_OFF);

    p_req_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_sn)
      lvl_req_o[b] |-> (|en_all[b*SRCS +: SRCS]));

    p_req_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_sn)
      lvl_req_o[b] |-> (|flag_all[b*SRCS +: SRCS]));

    p_flag_read_r9: assert property (@(posedge clk) disable iff (!rst_sn)
      (addr_i == FA) |-> (rdata_o[CTL_BIT] == lvl_req_o[b]) &&
                         (rdata_o[SRCS-1:0] == flag_all[b*SRCS +: SRCS]));

    p_en_read_r9: assert property (@(posedge clk) disable iff (!rst_sn)
      (addr_i == EA) |-> rdata_o[CTL_BIT] &&
                         (rdata_o[SRCS-1:0] == en_all[b*SRCS +: SRCS]));

    for (genvar i = 0; i < SRCS; i++) begin : g_i
      localparam int unsigned J = b*SRCS + i;

      p_edge_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_sn)
        $rose(src_i[J]) |=> flag_all[J]);

      p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_sn)
        (we_i && addr_i == FA && wdata_i[i] && !rise[J]) |=> !flag_all[J]);

      p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_sn)
        (rise[J] && we_i && addr_i == FA && wdata_i[i]) |=> flag_all[J]);

      p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_sn)
        (we_i && addr_i == EA && wdata_i[CTL_BIT] && wdata_i[i]) |=> en_all[J]);

      p_en_clr_r4: assert property (@(posedge clk) disable iff (!rst_sn)
        (we_i && addr_i == EA && !wdata_i[CTL_BIT] && wdata_i[i]) |=> !en_all[J]);
    end
  end
endmodule

bind irq_bank_ctrl irqb_checker #(
  .BANKS(BANKS), .SRCS(SRCS), .AW(AW), .DW(DW), .BASE(BASE), .STRIDE(STRIDE),
  .FLAG_OFF(FLAG_OFF), .EN_OFF(EN_OFF), .CTL_BIT(CTL_BIT)
) u_irqb_chk (
  .clk       (clk),
  .rst_sn    (rst_sn),
  .src_i     (src_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .lvl_req_o (lvl_req_o),
  .rise      (rise),
  .flag_all  (flag_all),
  .en_all    (en_all)
);

// File: tb/irq_bank_ctrl_test.sv
module irq_bank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [15:0] src = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h30;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  lvl;

  always #2 clk = ~clk;

  irq_bank_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src),
    .we_i      (we),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .lvl_req_o (lvl)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  int    rst_cnt = 0;
  bit    done = 1'b0;
  string phase = "R1";
  bit [3:0]  m_flag [4];
  bit [3:0]  m_en [4];
  bit [15:0] m_prev;

  function automatic bit [7:0] model_read(int a);
    int b, off;
    if (a < 'h30 || a >= 'h70) return 8'h00;
    b   = (a - 'h30) / 16;
    off = a % 16;
    if (off == 0) return {|(m_flag[b] & m_en[b]), 3'b000, m_flag[b]};
    if (off == 4) return {1'b1, 3'b000, m_en[b]};
    return 8'h00;
  endfunction

  task automatic check(string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    bit [15:0] rise;
    bit [3:0]  lv;
    int        b, off;
    if (!rst_n) begin
      rst_cnt = 0;
      m_prev  = '0;
      for (int k = 0; k < 4; k++) begin m_flag[k] = '0; m_en[k] = '0; end
    end else if (rst_cnt < 2) begin
      rst_cnt++;
    end else begin
      rise   = src & ~m_prev;
      m_prev = src;
      b   = (int'(addr) - 'h30) / 16;
      off = int'(addr) % 16;
      for (int k = 0; k < 4; k++) begin
        bit [3:0] clr;
        clr = '0;
        if (we && addr >= 8'h30 && addr < 8'h70 && b == k) begin
          if (off == 0) clr = wdata[3:0];
          if (off == 4) begin
            if (wdata[7]) m_en[k] = m_en[k] | wdata[3:0];
            else          m_en[k] = m_en[k] & ~wdata[3:0];
          end
        end
        m_flag[k] = (m_flag[k] & ~clr) | rise[4*k +: 4];
      end
    end
    #1;
    if (!done) begin
      for (int k = 0; k < 4; k++) lv[k] = |(m_flag[k] & m_en[k]);
      check("lvl_req", {4'h0, lvl}, {4'h0, lv});
      check("rdata", rdata, model_read(int'(addr)));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a);
    @(negedge clk);
    addr = a;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    phase = "R1";
    for (int k = 0; k < 4; k++) begin
      rd(8'(8'h30 + 16*k)); idle(1);
      rd(8'(8'h34 + 16*k)); idle(1);
    end

    phase = "R3";
    wr(8'h34, 8'h85); idle(2);
    wr(8'h34, 8'h82); idle(2);

    phase = "R4";
    wr(8'h34, 8'h01); idle(2);
    wr(8'h34, 8'h00); idle(2);

    phase = "R5";
    @(negedge clk) src[2] = 1'b1;
    rd(8'h30); idle(4);
    phase = "R6";
    wr(8'h30, 8'h00); idle(2);
    wr(8'h30, 8'h04); idle(4);
    phase = "R5";
    idle(3);
    @(negedge clk) src[2] = 1'b0;
    idle(2);

    phase = "R7";
    @(negedge clk);
    src[1] = 1'b1; we = 1'b1; addr = 8'h30; wdata = 8'h02;
    @(negedge clk) we = 1'b0;
    idle(3);
    wr(8'h30, 8'h02); idle(2);
    src[1] = 1'b0;

    phase = "R8";
    @(negedge clk) src[7] = 1'b1;
    rd(8'h40); idle(3);
    wr(8'h44, 8'h88); idle(3);
    wr(8'h44, 8'h08); idle(3);
    src[7] = 1'b0;

    phase = "R9";
    wr(8'h54, 8'hF0); idle(2);
    wr(8'h50, 8'h70); idle(2);
    wr(8'h54, 8'hFF); idle(2);
    @(negedge clk) src[11:8] = 4'hF;
    rd(8'h50); idle(3);

    phase = "R2";
    wr(8'h35, 8'hFF); idle(2);
    wr(8'h2F, 8'hFF); idle(2);
    wr(8'h70, 8'h8F); idle(2);
    wr(8'h38, 8'hFF); idle(2);
    wr(8'h5C, 8'h0F); idle(2);
    rd(8'h54); idle(1);
    rd(8'h50); idle(1);

    phase = "R10";
    for (int n = 0; n < 4000; n++) begin
      int pick;
      @(negedge clk);
      src  = 16'($urandom);
      pick = int'($urandom_range(0, 9));
      we   = ($urandom_range(0, 3) == 0);
      case (pick)
        0, 1, 2, 3: addr = 8'(8'h30 + 16*pick);
        4, 5, 6, 7: addr = 8'(8'h34 + 16*(pick-4));
        8:          addr = 8'($urandom_range(0, 255));
        default:    addr = 8'h72;
      endcase
      wdata = 8'($urandom);
    end
    @(negedge clk) we = 1'b0;
    idle(4);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule